// File: doc/BRIEF.md
# Reset Request Aggregator

The aggregator gathers every reset source in a power-control domain and turns them into one reset request with a cause code. There are four kinds of source. A vector of peripheral requests is conditional: each bit is gated by its own enable. A multi-bit software request is acted on only when it carries the one valid "true" code. An escalation request and a main-power-glitch indication are unconditional. Every source is latched as it arrives, so a single-cycle pulse is enough to start a full reset sequence.

A sequencer works through each reset in two phases. The first is a preparation phase, during which the peripheral clock enable is low. The second is a hold phase, during which the request vector, the cause code and the system reset are driven, along with the lifecycle reset if an unconditional source took part. A status register keeps the vector of the most recent reset until the next one replaces it. While the domain is in low power, wakeups are latched and acknowledged. A wakeup and a reset that arrive close together are served one after the other, in the order they arrived.

If the sequencer's state register ever holds an encoding that is not a legal state, it goes to a trap. In the trap it drives both reset outputs high and the clock enable low, and it stays there until the external reset is applied.

Top module: `rstreq_agg`

## Requirements
- R1: Peripheral request bit i enters the captured vector (bit i) only if `rst_en_i[i]` is 1 in the cycle it is sampled. A request whose enable is 0 starts no reset and leaves `status_o` unchanged.
- R2: Escalation always sets vector bit NUM_PERIPH, and the power glitch always sets bit NUM_PERIPH+1, whatever `rst_en_i` holds. Either one also drives `rst_lc_o` high for the hold phase.
- R3: During the hold phase `cause_o` is 1 (hardware) if any bit below NUM_PERIPH+2 is set, and 2 (software) if only the software bit is set. At all other times it is 0. When `cause_o` is 1, `req_o` equals the captured OR of the unconditional and enabled conditional requests.
- R4: A source pulsed for one cycle produces a complete reset. Sources that arrive during a reset are kept and start a further reset afterwards.
- R5: `clk_en_o` drops at the second rising edge after a source is sampled and stays low for PREP_CYC+HOLD_CYC cycles. The hold phase is always preceded by the preparation phase.
- R6: `rst_sys_o` is high for exactly HOLD_CYC cycles per reset, at the end of the low-clock window.
- R7: `status_o` takes the captured vector when the hold phase begins and keeps it until the next hold phase begins.
- R8: `wake_i` counts only while `low_power_i` is 1. Each wakeup taken gives `wake_ack_o` high for WAKE_CYC cycles, with `clk_en_o` high.
- R9: A wakeup and a reset are served one at a time in order of arrival. If both are sampled at the same edge, the wakeup is served first. `wake_ack_o` and `rst_sys_o` are never high together outside the trap.
- R10: The software request sets vector bit NUM_PERIPH+2 only when `sw_req_i` is 4'b0110. Every other code is ignored.
- R11: If the state register holds an illegal encoding, `rst_sys_o` and `rst_lc_o` are 1 and `clk_en_o` and `wake_ack_o` are 0 until `rst_ni` is asserted.
- R12: After reset, `clk_en_o` is 1, `status_o`, `req_o` and `cause_o` are 0, and `rst_sys_o`, `rst_lc_o` and `wake_ack_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| low_power_i | input | 1 | Domain is in low power; wakeups are sampled only while this is high |
| wake_i | input | 1 | Wakeup event |
| periph_req_i | input | NUM_PERIPH | Conditional peripheral reset requests |
| rst_en_i | input | NUM_PERIPH | Per-bit enable for the peripheral requests |
| esc_req_i | input | 1 | Escalation reset request (unconditional) |
| glitch_i | input | 1 | Main-power-glitch indication (unconditional) |
| sw_req_i | input | 4 | Software reset request, multi-bit; 4'b0110 means true |
| clk_en_o | output | 1 | Peripheral clock enable |
| rst_sys_o | output | 1 | System reset request |
| rst_lc_o | output | 1 | Lifecycle reset request |
| req_o | output | NUM_PERIPH+3 | Request vector during the hold phase |
| cause_o | output | 2 | 0 none, 1 hardware, 2 software |
| status_o | output | NUM_PERIPH+3 | Vector of the most recent reset |
| wake_ack_o | output | 1 | Wakeup being served |

## Verification
The bench builds the block with NUM_PERIPH=5, PREP_CYC=2, HOLD_CYC=3 and WAKE_CYC=2. The phases are short, so a wakeup or a second source can be made to land one edge before, at or after a reset in only a few cycles, which exercises the order-of-arrival rule and the same-edge tie. Five peripheral bits let the enable mask split a request into gated and passing parts. The trap is reached by forcing an illegal encoding into the state register, and the bench then checks that only the external reset clears it.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'b001,
        ST_PREP = 3'b010,
        ST_HOLD = 3'b100,
        ST_WAKE = 3'b111,
        ST_TRAP = 3'b110
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_HW   = 2'd1,
        CAUSE_SW   = 2'd2
    } cause_e;

    localparam int unsigned SW_REQ_W = 4;
    localparam logic [SW_REQ_W-1:0] SW_TRUE = 4'b0110;

endpackage

// File: rtl/rstreq_mask.sv
module rstreq_mask
    import rstreq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 4,
    localparam int unsigned REQ_W     = NUM_PERIPH + 3
) (
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic [NUM_PERIPH-1:0] rst_en_i,
    input  logic                  esc_req_i,
    input  logic                  glitch_i,
    input  logic [SW_REQ_W-1:0]   sw_req_i,
    output logic [REQ_W-1:0]      incoming_o
);

    localparam int unsigned ESC_IDX    = NUM_PERIPH;
    localparam int unsigned GLITCH_IDX = NUM_PERIPH + 1;
    localparam int unsigned SW_IDX     = NUM_PERIPH + 2;

    // Conditional class: one gate per peripheral source
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_cond
        assign incoming_o[i] = periph_req_i[i] & rst_en_i[i];
    end

    // Unconditional class
    assign incoming_o[ESC_IDX]    = esc_req_i;
    assign incoming_o[GLITCH_IDX] = glitch_i;

    // Software source: only the exact true code counts
    assign incoming_o[SW_IDX] = (sw_req_i == SW_TRUE);

endmodule

// File: rtl/rstreq_seq.sv
module rstreq_seq
    import rstreq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 4,
    parameter int unsigned PREP_CYC   = 3,
    parameter int unsigned HOLD_CYC   = 4,
    parameter int unsigned WAKE_CYC   = 2,
    localparam int unsigned REQ_W     = NUM_PERIPH + 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REQ_W-1:0] incoming_i,
    input  logic             wake_i,
    input  logic             low_power_i,
    output logic             clk_en_o,
    output logic             rst_sys_o,
    output logic             rst_lc_o,
    output logic [REQ_W-1:0] req_o,
    output logic [1:0]       cause_o,
    output logic [REQ_W-1:0] status_o,
    output logic             wake_ack_o
);

    localparam int unsigned ESC_IDX    = NUM_PERIPH;
    localparam int unsigned GLITCH_IDX = NUM_PERIPH + 1;
    localparam int unsigned SW_IDX     = NUM_PERIPH + 2;
    localparam int unsigned MAX_A      = (PREP_CYC > HOLD_CYC) ? PREP_CYC : HOLD_CYC;
    localparam int unsigned MAX_CYC    = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PREP_LAST = CNT_W'(PREP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REQ_W-1:0] pend;
        logic [REQ_W-1:0] cap;
        logic [REQ_W-1:0] status;
        logic             wpend;
    } seq_regs_t;

    seq_state_e state_d, state_q;
    seq_regs_t  d, q;
    logic       wake_hit;

    assign wake_hit = wake_i & low_power_i;

    // Next-value computation
    always_comb begin
        d       = q;
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (q.wpend) begin
                    // Wakeup latched earlier (or on the same edge) goes first
                    state_d = ST_WAKE;
                    d.cnt   = '0;
                    d.wpend = wake_hit;
                    d.pend  = q.pend | incoming_i;
                end else if (|q.pend) begin
                    state_d = ST_PREP;
                    d.cnt   = '0;
                    d.cap   = q.pend;
                    d.pend  = incoming_i;
                    d.wpend = wake_hit;
                end else begin
                    d.pend  = incoming_i;
                    d.wpend = wake_hit;
                end
            end
            ST_PREP: begin
                d.pend  = q.pend | incoming_i;
                d.wpend = q.wpend | wake_hit;
                if (q.cnt == PREP_LAST) begin
                    state_d  = ST_HOLD;
                    d.cnt    = '0;
                    d.status = q.cap;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_HOLD: begin
                d.pend  = q.pend | incoming_i;
                d.wpend = q.wpend | wake_hit;
                if (q.cnt == HOLD_LAST) begin
                    state_d = ST_IDLE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WAKE: begin
                d.pend  = q.pend | incoming_i;
                d.wpend = q.wpend | wake_hit;
                if (q.cnt == WAKE_LAST) begin
                    state_d = ST_IDLE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_TRAP: begin
                state_d = ST_TRAP;
            end
            default: begin
                state_d = ST_TRAP;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            q       <= '0;
        end else begin
            state_q <= state_d;
            q       <= d;
        end
    end

    // Output decode; any encoding outside the legal set lands on the trap values
    always_comb begin
        clk_en_o   = 1'b0;
        rst_sys_o  = 1'b1;
        rst_lc_o   = 1'b1;
        req_o      = '0;
        cause_o    = CAUSE_NONE;
        wake_ack_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                clk_en_o  = 1'b1;
                rst_sys_o = 1'b0;
                rst_lc_o  = 1'b0;
            end
            ST_WAKE: begin
                clk_en_o   = 1'b1;
                rst_sys_o  = 1'b0;
                rst_lc_o   = 1'b0;
                wake_ack_o = 1'b1;
            end
            ST_PREP: begin
                rst_sys_o = 1'b0;
                rst_lc_o  = 1'b0;
            end
            ST_HOLD: begin
                rst_lc_o = q.cap[ESC_IDX] | q.cap[GLITCH_IDX];
                req_o    = q.cap;
                cause_o  = (|q.cap[SW_IDX-1:0]) ? CAUSE_HW : CAUSE_SW;
            end
            default: begin
            end
        endcase
    end

    assign status_o = q.status;

    AST_PREP_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PREP) |-> !clk_en_o); // R5

    AST_NO_SKIP_PREP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |=> (state_q != ST_HOLD)); // R5

    AST_HW_VEC_LOGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_o == CAUSE_HW) |-> (req_o == status_o)); // R3

    AST_STATUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_PREP) |=> $stable(q.status)); // R7

    AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_sys_o |-> !wake_ack_o); // R9

    AST_TRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAP) |=> (state_q == ST_TRAP && rst_sys_o && !clk_en_o)); // R11

endmodule

// File: rtl/rstreq_agg.sv
module rstreq_agg
    import rstreq_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 4,
    parameter int unsigned PREP_CYC   = 3,
    parameter int unsigned HOLD_CYC   = 4,
    parameter int unsigned WAKE_CYC   = 2,
    localparam int unsigned REQ_W     = NUM_PERIPH + 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  low_power_i,
    input  logic                  wake_i,
    input  logic [NUM_PERIPH-1:0] periph_req_i,
    input  logic [NUM_PERIPH-1:0] rst_en_i,
    input  logic                  esc_req_i,
    input  logic                  glitch_i,
    input  logic [3:0]            sw_req_i,
    output logic                  clk_en_o,
    output logic                  rst_sys_o,
    output logic                  rst_lc_o,
    output logic [REQ_W-1:0]      req_o,
    output logic [1:0]            cause_o,
    output logic [REQ_W-1:0]      status_o,
    output logic                  wake_ack_o
);

    logic [REQ_W-1:0] incoming;

    rstreq_mask #(
        .NUM_PERIPH (NUM_PERIPH)
    ) u_mask (
        .periph_req_i (periph_req_i),
        .rst_en_i     (rst_en_i),
        .esc_req_i    (esc_req_i),
        .glitch_i     (glitch_i),
        .sw_req_i     (sw_req_i),
        .incoming_o   (incoming)
    );

    rstreq_seq #(
        .NUM_PERIPH (NUM_PERIPH),
        .PREP_CYC   (PREP_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .WAKE_CYC   (WAKE_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .incoming_i  (incoming),
        .wake_i      (wake_i),
        .low_power_i (low_power_i),
        .clk_en_o    (clk_en_o),
        .rst_sys_o   (rst_sys_o),
        .rst_lc_o    (rst_lc_o),
        .req_o       (req_o),
        .cause_o     (cause_o),
        .status_o    (status_o),
        .wake_ack_o  (wake_ack_o)
    );

endmodule

// File: tb/rstreq_agg_tb.sv
module rstreq_agg_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP    = 5;
    localparam int PREP  = 2;
    localparam int HOLD  = 3;
    localparam int WAKE  = 2;
    localparam int REQ_W = NP + 3;
    localparam int M_IDLE = 0, M_PREP = 1, M_HOLD = 2, M_WAKE = 3, M_TRAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_power = 1'b0;
    logic wake = 1'b0;
    logic [NP-1:0] periph = '0;
    logic [NP-1:0] en = '0;
    logic esc = 1'b0;
    logic glitch = 1'b0;
    logic [3:0] sw = 4'b1001;
    logic clk_en, rst_sys, rst_lc, wake_ack;
    logic [REQ_W-1:0] req, status;
    logic [1:0] cause;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int first_wake = -1;
    int first_rst = -1;
    int lowclk_cnt = 0;
    int sys_cnt = 0;
    int lc_cnt = 0;
    bit done = 0;
    string tag = "R12";

    // behavioural reference state
    int m_mode = M_IDLE;
    int m_cnt = 0;
    logic [REQ_W-1:0] m_pend = '0, m_cap = '0, m_status = '0;
    logic m_wpend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstreq_agg #(.NUM_PERIPH(NP), .PREP_CYC(PREP), .HOLD_CYC(HOLD), .WAKE_CYC(WAKE)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .low_power_i(low_power), .wake_i(wake),
        .periph_req_i(periph), .rst_en_i(en), .esc_req_i(esc), .glitch_i(glitch),
        .sw_req_i(sw), .clk_en_o(clk_en), .rst_sys_o(rst_sys), .rst_lc_o(rst_lc),
        .req_o(req), .cause_o(cause), .status_o(status), .wake_ack_o(wake_ack)
    );

    always @(posedge clk) begin
        logic [REQ_W-1:0] inc;
        logic wk;
        inc = '0;
        inc[NP-1:0] = periph & en;
        inc[NP] = esc;
        inc[NP+1] = glitch;
        inc[NP+2] = (sw == 4'b0110);
        wk = wake & low_power;
        if (!rst_n) begin
            m_mode = M_IDLE; m_cnt = 0; m_pend = '0; m_cap = '0; m_status = '0; m_wpend = 1'b0;
        end else if (m_mode == M_IDLE) begin
            if (m_wpend) begin
                m_mode = M_WAKE; m_cnt = 0; m_wpend = wk; m_pend = m_pend | inc;
            end else if (m_pend != 0) begin
                m_mode = M_PREP; m_cnt = 0; m_cap = m_pend; m_pend = inc; m_wpend = wk;
            end else begin
                m_pend = inc; m_wpend = wk;
            end
        end else if (m_mode != M_TRAP) begin
            m_pend = m_pend | inc;
            m_wpend = m_wpend | wk;
            if (m_mode == M_PREP && m_cnt == PREP-1) begin
                m_mode = M_HOLD; m_cnt = 0; m_status = m_cap;
            end else if ((m_mode == M_HOLD && m_cnt == HOLD-1) || (m_mode == M_WAKE && m_cnt == WAKE-1)) begin
                m_mode = M_IDLE; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    end

    task automatic compare();
        logic e_clk, e_sys, e_lc, e_wake;
        logic [REQ_W-1:0] e_req;
        logic [1:0] e_cause;
        e_clk  = (m_mode == M_IDLE || m_mode == M_WAKE);
        e_sys  = (m_mode == M_HOLD || m_mode == M_TRAP);
        e_lc   = (m_mode == M_TRAP) || (m_mode == M_HOLD && (m_cap[NP] || m_cap[NP+1]));
        e_req  = (m_mode == M_HOLD) ? m_cap : '0;
        e_cause = (m_mode != M_HOLD) ? 2'd0 : ((m_cap[NP+1:0] != 0) ? 2'd1 : 2'd2);
        e_wake = (m_mode == M_WAKE);
        tests++;
        if (clk_en !== e_clk || rst_sys !== e_sys || rst_lc !== e_lc || req !== e_req ||
            cause !== e_cause || status !== m_status || wake_ack !== e_wake) begin
            fails++;
            $display("FAIL %s cyc %0d: clk_en/sys/lc/wake=%b%b%b%b exp %b%b%b%b req=%h exp %h cause=%0d exp %0d status=%h exp %h",
                     tag, cyc, clk_en, rst_sys, rst_lc, wake_ack, e_clk, e_sys, e_lc, e_wake,
                     req, e_req, cause, e_cause, status, m_status);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare();
            if (wake_ack && first_wake < 0) first_wake = cyc;
            if (rst_sys && first_rst < 0) first_rst = cyc;
            if (!clk_en) lowclk_cnt++;
            if (rst_sys) sys_cnt++;
            if (rst_lc) lc_cnt++;
        end
    endtask

    task automatic mark();
        first_wake = -1; first_rst = -1; lowclk_cnt = 0; sys_cnt = 0; lc_cnt = 0;
    endtask

    task automatic chk(bit ok, string t, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state
        chk(clk_en == 1'b1 && rst_sys == 1'b0 && rst_lc == 1'b0, "R12", "idle outputs", {clk_en, rst_sys, rst_lc}, 3'b100);
        chk(status == '0 && cause == 2'd0 && req == '0, "R12", "status/cause", status, 0);

        // R1 masked conditional requests are ignored
        tag = "R1"; mark();
        en = 5'b00101;
        periph = 5'b01010; tick(1); periph = '0;
        tick(10);
        chk(lowclk_cnt == 0, "R1", "masked request clock-low cycles", lowclk_cnt, 0);
        chk(status == '0, "R1", "status after masked request", status, 0);
        // R1 enabled bit passes; R4 single-cycle pulse; R5/R6 window lengths
        mark();
        periph = 5'b00011; tick(1); periph = '0;
        tick(1);
        chk(clk_en == 1'b0, "R5", "clk_en two edges after sample", clk_en, 0);
        tick(PREP + HOLD + 4);
        chk(status == 8'h01, "R1", "status holds only enabled bit", status, 8'h01);
        chk(lowclk_cnt == PREP + HOLD, "R5", "clock-low window", lowclk_cnt, PREP + HOLD);
        chk(sys_cnt == HOLD, "R6", "system reset cycles", sys_cnt, HOLD);
        chk(lc_cnt == 0, "R6", "lifecycle reset for conditional source", lc_cnt, 0);

        // R2 escalation ignores enables
        tag = "R2"; mark();
        en = '0;
        esc = 1'b1; tick(1); esc = 1'b0;
        tick(PREP + HOLD + 3);
        chk(status == 8'h20, "R2", "escalation bit", status, 8'h20);
        chk(lc_cnt == HOLD, "R2", "lifecycle reset on escalation", lc_cnt, HOLD);
        mark();
        glitch = 1'b1; tick(1); glitch = 1'b0;
        tick(PREP + HOLD + 3);
        chk(status == 8'h40, "R2", "glitch bit", status, 8'h40);

        // R10 software encodings
        tag = "R10"; mark();
        sw = 4'b0111; tick(1); sw = 4'b1110; tick(1); sw = 4'b0000; tick(1); sw = 4'b1001;
        tick(8);
        chk(sys_cnt == 0 && status == 8'h40, "R10", "invalid software codes ignored", sys_cnt, 0);
        mark();
        sw = 4'b0110; tick(1); sw = 4'b1001;
        tick(PREP + 1);
        chk(cause == 2'd2, "R3", "software-only cause", cause, 2);
        tick(HOLD + 2);
        chk(status == 8'h80, "R10", "software bit", status, 8'h80);

        // R3 mixed sources -> hardware cause, full vector
        tag = "R3"; mark();
        en = 5'b10001;
        periph = 5'b11111; sw = 4'b0110; esc = 1'b1; tick(1);
        periph = '0; sw = 4'b1001; esc = 1'b0;
        tick(PREP + 1);
        chk(cause == 2'd1, "R3", "hardware cause", cause, 1);
        chk(req == 8'hB1, "R3", "request vector", req, 8'hB1);
        tick(HOLD + 2);

        // R4 source arriving during a reset gives a second reset
        tag = "R4"; mark();
        en = 5'b00100;
        periph = 5'b00100; tick(1); periph = '0;
        tick(2);
        glitch = 1'b1; tick(1); glitch = 1'b0;
        tick(2 * (PREP + HOLD) + 6);
        chk(sys_cnt == 2 * HOLD, "R4", "two resets", sys_cnt, 2 * HOLD);
        chk(status == 8'h40, "R7", "status from latest reset", status, 8'h40);

        // R8 wakeup only in low power
        tag = "R8"; mark();
        wake = 1'b1; tick(1); wake = 1'b0; tick(5);
        chk(first_wake < 0, "R8", "wakeup outside low power ignored", first_wake, -1);
        low_power = 1'b1;
        wake = 1'b1; tick(1); wake = 1'b0; tick(WAKE + 3);
        chk(first_wake > 0, "R8", "wakeup acknowledged", first_wake, 1);

        // R9 wakeup then reset
        tag = "R9"; mark();
        en = 5'b11111;
        wake = 1'b1; tick(1); wake = 1'b0;
        periph = 5'b00001; tick(1); periph = '0;
        tick(WAKE + PREP + HOLD + 4);
        chk(first_wake >= 0 && first_rst > first_wake, "R9", "wake before later reset", first_rst, first_wake + 1);
        // reset then wakeup
        mark();
        esc = 1'b1; tick(1); esc = 1'b0;
        wake = 1'b1; tick(1); wake = 1'b0;
        tick(WAKE + PREP + HOLD + 4);
        chk(first_wake > first_rst && first_rst >= 0, "R9", "reset before later wake", first_wake, first_rst + 1);
        // same edge: wakeup first
        mark();
        esc = 1'b1; wake = 1'b1; tick(1); esc = 1'b0; wake = 1'b0;
        tick(WAKE + PREP + HOLD + 4);
        chk(first_wake >= 0 && first_rst > first_wake, "R9", "tie served wake first", first_rst, first_wake + 1);
        low_power = 1'b0;

        // R11 illegal state encoding
        tag = "R11"; mark();
        tick(2);
        force u_dut.u_seq.state_q = rstreq_pkg::seq_state_e'(3'b000);
        m_mode = M_TRAP;
        @(posedge clk);
        #1;
        release u_dut.u_seq.state_q;
        periph = 5'b11111; wake = 1'b1; low_power = 1'b1;
        tick(6);
        periph = '0; wake = 1'b0; low_power = 1'b0;
        chk(rst_sys == 1'b1 && rst_lc == 1'b1 && clk_en == 1'b0 && wake_ack == 1'b0, "R11",
            "trap outputs", {rst_sys, rst_lc, clk_en, wake_ack}, 4'b1100);
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
        tag = "R12";
        chk(clk_en == 1'b1 && rst_sys == 1'b0 && status == '0, "R12", "recovered by external reset", clk_en, 1);

        tick(3);
        finish_run();
    end

endmodule